// File: doc/BRIEF.md
# Flash Erase-Block Select Register File

This block is the register file that chooses which flash block an erase may touch. It holds two block-select registers and a sticky error flag. All three are reached over a small synchronous bus with an address, a write strobe, write data and registered read data. The two select registers together form one select vector. The block keeps that vector at most one-hot. A write that would leave more than one bit set wipes both registers.

Several conditions force the selection back to zero:

- a synchronous reset;
- either standby mode;
- the flash write-enable pin going low;
- the software write-enable bit being clear.

When on-chip flash is disabled, the select registers read as zero and ignore writes. A single-cycle error pulse from the erase/program sequencer sets the error flag. Only reset or hardware standby can clear that flag. While the flag is set, the erase permit output stays low and select writes are dropped.

Top module: `flash_erase_sel`

## Requirements
- R1: While `rst` is high, and on the cycle after it, both select registers, the error flag, `erase_permit_o` and `err_protect_o` are 0. A status read after reset returns 0x00.
- R2: The bus map is as follows. Address 0 is the low select register, which drives `blk_sel_o[7:0]`. Address 1 is the high select register, which drives `blk_sel_o[15:8]` and sits in bus bits 7:0. Address 2 is status, with the error flag in bit 7 and bits 6:0 reading 0. Any other address reads 0x00. `bus_rdata_o` shows the addressed register one clock after the address is presented. A write shows on `blk_sel_o` one clock after the write strobe.
- R3: If the value a select write would produce has more than one set bit across both registers, both registers become 0x00 instead.
- R4: Both select registers are 0 on the cycle after any of these holds: `hw_standby_i` high, `sw_standby_i` high, `wr_pin_i` low, or `sw_wen_i` low. A select write in such a cycle is dropped.
- R5: While `flash_en_i` is low, reads of addresses 0 and 1 return 0x00 and select writes leave `blk_sel_o` unchanged. The status register still reads normally.
- R6: A one-cycle high on `err_evt_i` makes `err_protect_o` high from the next cycle on.
- R7: Once set, the error flag stays set until `rst` or `hw_standby_i`. Writes to the status address have no effect on it.
- R8: While the error flag is set, or in the cycle an error pulse arrives, select writes are ignored. `erase_permit_o` is high exactly when some select bit is set and the error flag is clear.
- R9: A write of 0x00 to one select register clears that register only and leaves the other one as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| hw_standby_i | input | 1 | Hardware standby mode active |
| sw_standby_i | input | 1 | Software standby mode active |
| wr_pin_i | input | 1 | Flash write-enable pin level |
| sw_wen_i | input | 1 | Software write-enable bit |
| flash_en_i | input | 1 | On-chip flash enabled |
| err_evt_i | input | 1 | Single-cycle program/erase error pulse |
| bus_addr_i | input | 4 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| blk_sel_o | output | 16 | Combined select vector {high, low} |
| erase_permit_o | output | 1 | Erase allowed on the selected block |
| err_protect_o | output | 1 | Error-protection state (error flag) |

## Verification
Two pairs of events can land in the same cycle. The first pair is a select write and an error pulse. The second pair is a select write and a forced-clear condition such as software standby or the write-enable pin going low.

The bench drives the write strobe and the competing input on the same falling edge, so both are sampled on one rising edge. In both cases the write must lose. After an error pulse, `blk_sel_o` must keep its previous value and `erase_permit_o` must drop. After a forced clear, the vector must read zero on the next cycle.

// File: rtl/flash_esel_pkg.sv
package flash_esel_pkg;

  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_LO   = 2'd1,
    RD_HI   = 2'd2,
    RD_STAT = 2'd3
  } esel_rd_e;

endpackage

// File: rtl/esel_decode.sv
module esel_decode #(
  parameter int ADDR_W    = 4,
  parameter int ADDR_LO   = 0,
  parameter int ADDR_HI   = 1,
  parameter int ADDR_STAT = 2
) (
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic                      we_i,
  input  logic                      wr_allow_i,
  output logic                      wr_lo_o,
  output logic                      wr_hi_o,
  output flash_esel_pkg::esel_rd_e  rd_sel_o
);
  import flash_esel_pkg::*;

  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(ADDR_LO);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(ADDR_HI);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(ADDR_STAT);

  logic hit_lo, hit_hi, hit_st;

  always_comb begin
    hit_lo = (addr_i == A_LO);
    hit_hi = (addr_i == A_HI);
    hit_st = (addr_i == A_ST);
    wr_lo_o = we_i && wr_allow_i && hit_lo;
    wr_hi_o = we_i && wr_allow_i && hit_hi;
    if (hit_lo)      rd_sel_o = RD_LO;
    else if (hit_hi) rd_sel_o = RD_HI;
    else if (hit_st) rd_sel_o = RD_STAT;
    else             rd_sel_o = RD_NONE;
  end

endmodule

// File: rtl/esel_sel_regs.sv
module esel_sel_regs #(
  parameter int DATA_W   = 8,
  parameter int SEL_LO_W = 8,
  parameter int SEL_HI_W = 8,
  localparam int SEL_W   = SEL_LO_W + SEL_HI_W
) (
  input  logic                clk,
  input  logic                clr_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [SEL_LO_W-1:0] sel_lo_o,
  output logic [SEL_HI_W-1:0] sel_hi_o,
  output logic [SEL_W-1:0]    sel_next_o
);

  logic [SEL_LO_W-1:0] lo_q, lo_cand;
  logic [SEL_HI_W-1:0] hi_q, hi_cand;
  logic [SEL_W-1:0]    cand, nxt;
  logic                multi;

  always_comb begin
    lo_cand = wr_lo_i ? wdata_i[SEL_LO_W-1:0] : lo_q;
    hi_cand = wr_hi_i ? wdata_i[SEL_HI_W-1:0] : hi_q;
    cand    = {hi_cand, lo_cand};
    multi   = ($countones(cand) > 1);
    if (clr_i || multi) nxt = '0;
    else                nxt = cand;
  end

  always_ff @(posedge clk) begin
    lo_q <= nxt[SEL_LO_W-1:0];
    hi_q <= nxt[SEL_W-1:SEL_LO_W];
  end

  assign sel_lo_o   = lo_q;
  assign sel_hi_o   = hi_q;
  assign sel_next_o = nxt;

endmodule

// File: rtl/esel_err_flag.sv
module esel_err_flag (
  input  logic clk,
  input  logic clr_i,
  input  logic evt_i,
  output logic flag_o,
  output logic flag_next_o
);

  logic flag_q, nxt;

  always_comb begin
    if (clr_i) nxt = 1'b0;
    else       nxt = flag_q | evt_i;
  end

  always_ff @(posedge clk) flag_q <= nxt;

  assign flag_o      = flag_q;
  assign flag_next_o = nxt;

endmodule

// File: rtl/flash_erase_sel.sv
module flash_erase_sel #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int SEL_LO_W  = 8,
  parameter int SEL_HI_W  = 8,
  parameter int ADDR_LO   = 0,
  parameter int ADDR_HI   = 1,
  parameter int ADDR_STAT = 2,
  localparam int SEL_W    = SEL_LO_W + SEL_HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hw_standby_i,
  input  logic              sw_standby_i,
  input  logic              wr_pin_i,
  input  logic              sw_wen_i,
  input  logic              flash_en_i,
  input  logic              err_evt_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [SEL_W-1:0]  blk_sel_o,
  output logic              erase_permit_o,
  output logic              err_protect_o
);
  import flash_esel_pkg::*;

  logic                sel_clr, err_clr, wr_allow;
  logic                wr_lo, wr_hi;
  esel_rd_e            rd_sel;
  logic [SEL_LO_W-1:0] sel_lo;
  logic [SEL_HI_W-1:0] sel_hi;
  logic [SEL_W-1:0]    sel_next;
  logic                err_q, err_next;
  logic [DATA_W-1:0]   rd_lo, rd_hi, rd_st, rd_nxt;
  logic                permit_q;
  logic [DATA_W-1:0]   rdata_q;

  always_comb begin
    sel_clr  = rst || hw_standby_i || sw_standby_i || !wr_pin_i || !sw_wen_i;
    err_clr  = rst || hw_standby_i;
    wr_allow = flash_en_i && !err_q && !err_evt_i;
  end

  esel_decode #(
    .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO), .ADDR_HI(ADDR_HI), .ADDR_STAT(ADDR_STAT)
  ) u_dec (
    .addr_i(bus_addr_i), .we_i(bus_we_i), .wr_allow_i(wr_allow),
    .wr_lo_o(wr_lo), .wr_hi_o(wr_hi), .rd_sel_o(rd_sel)
  );

  esel_sel_regs #(
    .DATA_W(DATA_W), .SEL_LO_W(SEL_LO_W), .SEL_HI_W(SEL_HI_W)
  ) u_regs (
    .clk(clk), .clr_i(sel_clr), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi),
    .wdata_i(bus_wdata_i), .sel_lo_o(sel_lo), .sel_hi_o(sel_hi),
    .sel_next_o(sel_next)
  );

  esel_err_flag u_err (
    .clk(clk), .clr_i(err_clr), .evt_i(err_evt_i),
    .flag_o(err_q), .flag_next_o(err_next)
  );

  always_comb begin
    rd_lo = '0;
    rd_hi = '0;
    rd_st = '0;
    rd_lo[SEL_LO_W-1:0] = sel_lo;
    rd_hi[SEL_HI_W-1:0] = sel_hi;
    rd_st[DATA_W-1]     = err_q;
    case (rd_sel)
      RD_LO:   rd_nxt = flash_en_i ? rd_lo : '0;
      RD_HI:   rd_nxt = flash_en_i ? rd_hi : '0;
      RD_STAT: rd_nxt = rd_st;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q  <= '0;
      permit_q <= 1'b0;
    end else begin
      rdata_q  <= rd_nxt;
      permit_q <= (|sel_next) && !err_next;
    end
  end

  assign bus_rdata_o    = rdata_q;
  assign blk_sel_o      = {sel_hi, sel_lo};
  assign erase_permit_o = permit_q;
  assign err_protect_o  = err_q;

endmodule

// File: rtl/esel_chk.sv
module esel_chk #(
  parameter int SEL_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             hw_standby_i,
  input logic             sw_standby_i,
  input logic             wr_pin_i,
  input logic             sw_wen_i,
  input logic             flash_en_i,
  input logic             err_evt_i,
  input logic [SEL_W-1:0] blk_sel_o,
  input logic             erase_permit_o,
  input logic             err_protect_o
);

  logic frc;
  assign frc = hw_standby_i || sw_standby_i || !wr_pin_i || !sw_wen_i;

  // R3
  onehot_sel_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(blk_sel_o) <= 1);

  // R4
  force_clear_chk: assert property (@(posedge clk) disable iff (rst)
    frc |=> (blk_sel_o == '0));

  // R5
  disabled_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!flash_en_i && !frc) |=> $stable(blk_sel_o));

  // R6
  err_set_chk: assert property (@(posedge clk) disable iff (rst)
    (err_evt_i && !hw_standby_i) |=> err_protect_o);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (err_protect_o && !hw_standby_i) |=> err_protect_o);

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((err_protect_o || err_evt_i) && !frc) |=> $stable(blk_sel_o));

  // R8
  permit_chk: assert property (@(posedge clk) disable iff (rst)
    erase_permit_o |-> (!err_protect_o && (blk_sel_o != '0)));

endmodule

bind flash_erase_sel esel_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst), .hw_standby_i(hw_standby_i), .sw_standby_i(sw_standby_i),
  .wr_pin_i(wr_pin_i), .sw_wen_i(sw_wen_i), .flash_en_i(flash_en_i),
  .err_evt_i(err_evt_i), .blk_sel_o(blk_sel_o), .erase_permit_o(erase_permit_o),
  .err_protect_o(err_protect_o)
);

// File: tb/tb_flash_erase_sel.sv
`timescale 1ns/1ps
module tb_flash_erase_sel;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hw_sb = 1'b0, sw_sb = 1'b0, pin = 1'b1, swen = 1'b1;
  logic       fen = 1'b1, evt = 1'b0;
  logic [3:0] addr = '0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [15:0] sel;
  logic       permit, prot;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  flash_erase_sel dut (
    .clk(clk), .rst(rst), .hw_standby_i(hw_sb), .sw_standby_i(sw_sb),
    .wr_pin_i(pin), .sw_wen_i(swen), .flash_en_i(fen), .err_evt_i(evt),
    .bus_addr_i(addr), .bus_we_i(we), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .blk_sel_o(sel), .erase_permit_o(permit),
    .err_protect_o(prot)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a;
    tick();
    d = rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 sel", sel, 16'h0);
    check("R1 permit", {15'h0, permit}, 16'h0);
    check("R1 protect", {15'h0, prot}, 16'h0);
    rd(4'd2, d);
    check("R1 status", {8'h0, d}, 16'h0);
  endtask

  task automatic t_map();
    logic [7:0] d;
    wr(4'd0, 8'h04);
    check("R2 low write", sel, 16'h0004);
    check("R8 permit on", {15'h0, permit}, 16'h1);
    rd(4'd0, d);
    check("R2 low read", {8'h0, d}, 16'h0004);
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h01);
    check("R2 high write", sel, 16'h0100);
    rd(4'd1, d);
    check("R2 high read", {8'h0, d}, 16'h0001);
    rd(4'd3, d);
    check("R2 unmapped read", {8'h0, d}, 16'h0000);
    wr(4'd0, 8'h00);
    check("R9 zero low keeps high", sel, 16'h0100);
    wr(4'd1, 8'h00);
    check("R9 zero high", sel, 16'h0000);
    check("R8 permit off", {15'h0, permit}, 16'h0);
  endtask

  task automatic t_multi();
    wr(4'd0, 8'h04);
    wr(4'd1, 8'h80);
    check("R3 cross-register two bits", sel, 16'h0000);
    wr(4'd0, 8'h03);
    check("R3 same-register two bits", sel, 16'h0000);
    wr(4'd1, 8'h40);
    check("R3 single bit accepted", sel, 16'h4000);
    wr(4'd1, 8'h00);
  endtask

  task automatic t_force();
    wr(4'd0, 8'h10);
    pin = 1'b0; tick(); pin = 1'b1;
    check("R4 pin low", sel, 16'h0);
    wr(4'd0, 8'h10);
    swen = 1'b0; tick(); swen = 1'b1;
    check("R4 sw enable low", sel, 16'h0);
    wr(4'd0, 8'h10);
    hw_sb = 1'b1; tick(); hw_sb = 1'b0;
    check("R4 hw standby", sel, 16'h0);
    wr(4'd0, 8'h10);
    sw_sb = 1'b1; wr(4'd0, 8'h08); sw_sb = 1'b0;
    check("R4 write during sw standby dropped", sel, 16'h0);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    wr(4'd0, 8'h20);
    fen = 1'b0;
    rd(4'd0, d);
    check("R5 read while disabled", {8'h0, d}, 16'h0);
    wr(4'd0, 8'h01);
    check("R5 write while disabled", sel, 16'h0020);
    rd(4'd2, d);
    check("R5 status while disabled", {8'h0, d}, 16'h0);
    fen = 1'b1;
    rd(4'd0, d);
    check("R5 read re-enabled", {8'h0, d}, 16'h0020);
  endtask

  task automatic t_error();
    logic [7:0] d;
    evt = 1'b1; wr(4'd0, 8'h01); evt = 1'b0;
    check("R6 protect set", {15'h0, prot}, 16'h1);
    check("R8 same-cycle write dropped", sel, 16'h0020);
    check("R8 permit low on error", {15'h0, permit}, 16'h0);
    wr(4'd2, 8'h00);
    rd(4'd2, d);
    check("R7 status write ignored", {8'h0, d}, 16'h0080);
    wr(4'd0, 8'h02);
    check("R8 write while flagged", sel, 16'h0020);
    tick();
    check("R7 flag sticky", {15'h0, prot}, 16'h1);
    hw_sb = 1'b1; tick(); hw_sb = 1'b0;
    check("R7 hw standby clears", {15'h0, prot}, 16'h0);
    evt = 1'b1; tick(); evt = 1'b0;
    rst = 1'b1; tick(); rst = 1'b0;
    check("R7 reset clears flag", {15'h0, prot}, 16'h0);
    check("R1 reset clears sel", sel, 16'h0);
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    t_reset();
    t_map();
    t_multi();
    t_force();
    t_disable();
    t_error();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule